// File: doc/BRIEF.md
# Timer Event and Interrupt Controller

This block gathers timing events from a clock subsystem into one sticky event register. A mask register with the same bit layout selects which pending events raise the single interrupt line. Three kinds of source feed it: edges on two external trigger pins, two alarm-match strobes and three periodic-pulse strobes. An external block produces the alarm and pulse strobes and delivers each as a one-cycle pulse.

Each trigger pin passes through a two-flop synchronizer and then an edge detector. A control bit sets the detector's polarity for each pin. On a qualifying edge, the block copies the current 64-bit time into that trigger's capture register and sets the trigger's event bit. Software reads the registers through a simple word-addressed port. It clears each event it has handled by writing a one at that bit position.

Register word addresses: 0 event, 1 mask, 2 status, 3 control, 4 trigger 1 stamp high word, 5 trigger 1 stamp low word, 6 trigger 2 stamp high word, 7 trigger 2 stamp low word. Unimplemented bits read as zero.

Top module: `tev_ctrl`

## Requirements
- R1: An event bit becomes set in the edge after its source fires and stays set until software clears it. The bit positions are: trigger 2 at bit 25, trigger 1 at bit 24, alarm 2 at bit 17, alarm 1 at bit 16, pulse 1 at bit 7, pulse 2 at bit 6, pulse 3 at bit 5.
- R2: A write to the event register (address 0) clears every implemented event bit whose written value is one.
- R3: Written zeros leave event bits unchanged. A write of all zeros changes nothing.
- R4: When a source sets a bit in the same cycle that software clears it, the bit ends up set.
- R5: The mask register (address 1) uses the event bit positions and accepts writes only at implemented bits. `irq_o` is high exactly when some event bit and the same mask bit are both one.
- R6: A trigger edge copies the full 64-bit `time_i` into that trigger's capture register. Software reads the high word at addresses 4 and 6 and the low word at addresses 5 and 7. A later capture overwrites the earlier one.
- R7: Control register bit 8 selects the edge for trigger 1 and bit 9 selects it for trigger 2. A value of 0 selects the rising edge and 1 selects the falling edge. The edge of the other direction is ignored. All other control bits read as zero.
- R8: A trigger pin change is sampled through two synchronizer flops. The capture and its event bit therefore appear on the third rising clock edge after the pin changes, and not before.
- R9: Bits 5:0 of the status register (address 2) read `stat_vec_i`. Bits 31:6 read as zero.
- R10: After reset, every register reads zero and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_i | input | 64 | Current time value |
| trig_i | input | 2 | External trigger pins, bit 0 is trigger 1 |
| alarm_stb_i | input | 2 | Alarm match strobes, bit 0 is alarm 1 |
| pulse_stb_i | input | 3 | Periodic pulse strobes, bit 0 is pulse 1 |
| stat_vec_i | input | 6 | General purpose status vector |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| irq_o | output | 1 | Interrupt request |

## Verification
The embedded properties check on every cycle that a hardware set lands in the event register, including when it collides with a clear. They also check that written ones clear, that an idle register holds its value, and that a captured stamp equals the time sampled at the detected edge. Other behaviour only the directed scenarios can show. That covers the mapping of each source to its bit position, the exact three-edge synchronizer latency, the rejection of an edge of the wrong polarity, the word order of the stamp readback and the status passthrough.

// File: rtl/tev_pkg.sv
package tev_pkg;
    localparam int DATA_W  = 32;
    localparam int TIME_W  = 64;
    localparam int ADDR_W  = 3;
    localparam int N_TRIG  = 2;
    localparam int N_ALARM = 2;
    localparam int N_PULSE = 3;
    localparam int STAT_W  = 6;

    // software decodes these positions
    localparam int BIT_TRIG1  = 24;
    localparam int BIT_ALARM1 = 16;
    localparam int BIT_PULSE1 = 7;   // pulses count downward
    localparam int BIT_POL1   = 8;   // control: edge select of trigger 1

    typedef enum logic [ADDR_W-1:0] {
        A_EVENT  = 3'd0,
        A_MASK   = 3'd1,
        A_STATUS = 3'd2,
        A_CTRL   = 3'd3,
        A_T1_HI  = 3'd4,
        A_T1_LO  = 3'd5,
        A_T2_HI  = 3'd6,
        A_T2_LO  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic [N_TRIG-1:0]  trig;
        logic [N_ALARM-1:0] alarm;
        logic [N_PULSE-1:0] pulse;
    } src_hits_t;

    function automatic logic [DATA_W-1:0] hits_to_vec(src_hits_t h);
        logic [DATA_W-1:0] v;
        v = '0;
        for (int i = 0; i < N_TRIG; i++)  v[BIT_TRIG1 + i]  = h.trig[i];
        for (int i = 0; i < N_ALARM; i++) v[BIT_ALARM1 + i] = h.alarm[i];
        for (int i = 0; i < N_PULSE; i++) v[BIT_PULSE1 - i] = h.pulse[i];
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] impl_bits();
        src_hits_t all;
        all.trig  = '1;
        all.alarm = '1;
        all.pulse = '1;
        return hits_to_vec(all);
    endfunction
endpackage

// File: rtl/tev_trig_capture.sv
module tev_trig_capture #(
    parameter int TIME_W      = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_i,
    input  logic              fall_sel_i,
    input  logic [TIME_W-1:0] time_i,
    output logic              hit_o,
    output logic [TIME_W-1:0] stamp_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic [TIME_W-1:0]      stamp_q;
    logic                   cur;

    assign cur = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '0;
            prev_q  <= 1'b0;
            stamp_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            prev_q <= cur;
            if (hit_o) stamp_q <= time_i;
        end
    end

    always_comb begin
        if (fall_sel_i) hit_o = prev_q & ~cur;
        else            hit_o = cur & ~prev_q;
    end

    assign stamp_o = stamp_q;

    // R6
    stamp_take_chk: assert property (@(posedge clk) disable iff (rst)
        hit_o |=> (stamp_q == $past(time_i)));
    // R6
    stamp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !hit_o |=> $stable(stamp_q));
endmodule

// File: rtl/tev_event_bank.sv
module tev_event_bank
    import tev_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] set_i,
    input  logic              ev_wr_i,
    input  logic              mask_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] event_o,
    output logic [DATA_W-1:0] mask_o,
    output logic              irq_o
);
    localparam logic [DATA_W-1:0] IMPL = impl_bits();

    logic [DATA_W-1:0] ev_q, mask_q, clr;

    assign clr = ev_wr_i ? (wdata_i & IMPL) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_q   <= '0;
            mask_q <= '0;
        end else begin
            ev_q <= (ev_q & ~clr) | (set_i & IMPL);
            if (mask_wr_i) mask_q <= wdata_i & IMPL;
        end
    end

    assign event_o = ev_q;
    assign mask_o  = mask_q;
    assign irq_o   = |(ev_q & mask_q);

    // R1 R4
    hw_set_chk: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((ev_q & $past(set_i & IMPL)) == $past(set_i & IMPL)));
    // R2
    sw_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_wr_i && ((wdata_i & ~set_i & IMPL) != '0))
        |=> ((ev_q & $past(wdata_i & ~set_i & IMPL)) == '0));
    // R1 R3
    ev_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ((set_i == '0) && (!ev_wr_i || wdata_i == '0)) |=> $stable(ev_q));
endmodule

// File: rtl/tev_ctrl.sv
module tev_ctrl
    import tev_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [63:0]       time_i,
    input  logic [1:0]        trig_i,
    input  logic [1:0]        alarm_stb_i,
    input  logic [2:0]        pulse_stb_i,
    input  logic [5:0]        stat_vec_i,
    input  logic              reg_wr_i,
    input  logic [2:0]        reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              irq_o
);
    localparam int HALF = TIME_W / 2;

    logic [N_TRIG-1:0] pol_q;
    logic [N_TRIG-1:0] trig_hit;
    logic [TIME_W-1:0] stamp [N_TRIG];
    src_hits_t         hits;
    logic [DATA_W-1:0] ev_vec, mask_vec;
    reg_addr_e         addr;

    assign addr = reg_addr_e'(reg_addr_i);

    always_ff @(posedge clk) begin
        if (rst) pol_q <= '0;
        else if (reg_wr_i && addr == A_CTRL)
            pol_q <= reg_wdata_i[BIT_POL1 +: N_TRIG];
    end

    for (genvar t = 0; t < N_TRIG; t++) begin : g_trig
        tev_trig_capture #(.TIME_W(TIME_W), .SYNC_STAGES(2)) u_cap (
            .clk        (clk),
            .rst        (rst),
            .pin_i      (trig_i[t]),
            .fall_sel_i (pol_q[t]),
            .time_i     (time_i),
            .hit_o      (trig_hit[t]),
            .stamp_o    (stamp[t])
        );
    end

    assign hits.trig  = trig_hit;
    assign hits.alarm = alarm_stb_i;
    assign hits.pulse = pulse_stb_i;

    tev_event_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .set_i     (hits_to_vec(hits)),
        .ev_wr_i   (reg_wr_i && addr == A_EVENT),
        .mask_wr_i (reg_wr_i && addr == A_MASK),
        .wdata_i   (reg_wdata_i),
        .event_o   (ev_vec),
        .mask_o    (mask_vec),
        .irq_o     (irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        unique case (addr)
            A_EVENT:  reg_rdata_o = ev_vec;
            A_MASK:   reg_rdata_o = mask_vec;
            A_STATUS: reg_rdata_o[STAT_W-1:0] = stat_vec_i;
            A_CTRL:   reg_rdata_o[BIT_POL1 +: N_TRIG] = pol_q;
            A_T1_HI:  reg_rdata_o = stamp[0][TIME_W-1:HALF];
            A_T1_LO:  reg_rdata_o = stamp[0][HALF-1:0];
            A_T2_HI:  reg_rdata_o = stamp[1][TIME_W-1:HALF];
            A_T2_LO:  reg_rdata_o = stamp[1][HALF-1:0];
            default:  reg_rdata_o = '0;
        endcase
    end

    // R5
    irq_mask_off_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_i && addr == A_MASK && reg_wdata_i == '0) |=> !irq_o);
    // R5
    irq_from_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !reg_wr_i) |=> (irq_o || $past(mask_vec) != mask_vec || $fell(|ev_vec)));
endmodule

// File: tb/test_tev_ctrl.sv
module test_tev_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] time_i = '0;
    logic [1:0]  trig_i = '0;
    logic [1:0]  alarm_stb_i = '0;
    logic [2:0]  pulse_stb_i = '0;
    logic [5:0]  stat_vec_i = '0;
    logic        reg_wr_i = 1'b0;
    logic [2:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        irq_o;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    tev_ctrl i_tev_ctrl (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        reg_addr_i = a;
        #1 d = reg_rdata_o;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic test_reset();
        logic [31:0] d;
        for (int a = 0; a < 8; a++) begin
            if (a == 2) continue;
            rd(3'(a), d);
            chk("R10 reset reg", d, 32'h0);
        end
        chk("R10 reset irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic test_sources();
        logic [31:0] d;
        @(negedge clk);
        alarm_stb_i = 2'b11; pulse_stb_i = 3'b111;
        @(negedge clk);
        alarm_stb_i = '0; pulse_stb_i = '0;
        rd(0, d);
        chk("R1 alarm/pulse bit positions", d, 32'h0003_00E0);
        idle(3);
        rd(0, d);
        chk("R1 sticky", d, 32'h0003_00E0);
    endtask

    task automatic test_clear();
        logic [31:0] d;
        wr(0, 32'h0);
        rd(0, d);
        chk("R3 zero write", d, 32'h0003_00E0);
        wr(0, 32'h0001_0040);
        rd(0, d);
        chk("R2 w1c partial", d, 32'h0002_00A0);
        wr(0, 32'hFFFF_FFFF);
        rd(0, d);
        chk("R2 w1c all", d, 32'h0);
    endtask

    task automatic test_collide();
        logic [31:0] d;
        @(negedge clk);
        pulse_stb_i = 3'b001;
        reg_addr_i = 0; reg_wdata_i = 32'h80; reg_wr_i = 1'b1;
        @(negedge clk);
        pulse_stb_i = '0; reg_wr_i = 1'b0;
        rd(0, d);
        chk("R4 set wins", d, 32'h80);
    endtask

    task automatic test_mask();
        logic [31:0] d;
        wr(1, 32'hFFFF_FFFF);
        rd(1, d);
        chk("R5 mask impl bits", d, 32'h0303_00E0);
        chk("R5 irq on", {31'b0, irq_o}, 32'h1);
        wr(1, 32'h0001_0000);
        chk("R5 irq masked", {31'b0, irq_o}, 32'h0);
        wr(1, 32'h0000_0080);
        chk("R5 irq match", {31'b0, irq_o}, 32'h1);
        wr(0, 32'h80);
        chk("R5 irq after clear", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic test_capture();
        logic [31:0] d;
        @(negedge clk);
        time_i = 64'h1234_5678_9ABC_DEF0;
        trig_i[0] = 1'b1;
        idle(2);
        rd(0, d);
        chk("R8 no capture after two edges", d, 32'h0);
        idle(1);
        rd(0, d);
        chk("R8 R1 trigger 1 at third edge", d, 32'h0100_0000);
        time_i = 64'hFFFF_0000_1111_2222;
        rd(4, d);
        chk("R6 trig1 hi", d, 32'h1234_5678);
        rd(5, d);
        chk("R6 trig1 lo", d, 32'h9ABC_DEF0);
        trig_i[1] = 1'b1;
        idle(4);
        rd(0, d);
        chk("R1 trigger 2 bit", d, 32'h0300_0000);
        rd(6, d);
        chk("R6 trig2 hi", d, 32'hFFFF_0000);
        rd(7, d);
        chk("R6 trig2 lo", d, 32'h1111_2222);
        wr(0, 32'h0300_0000);
    endtask

    task automatic test_polarity();
        logic [31:0] d;
        trig_i = 2'b00;
        idle(4);
        wr(3, 32'hFFFF_FFFF);
        rd(3, d);
        chk("R7 ctrl readback", d, 32'h0000_0300);
        wr(0, 32'hFFFF_FFFF);
        time_i = 64'hAAAA_BBBB_CCCC_DDDD;
        trig_i[0] = 1'b1;
        idle(5);
        rd(0, d);
        chk("R7 rising ignored", d, 32'h0);
        rd(5, d);
        chk("R7 stamp kept", d, 32'h9ABC_DEF0);
        trig_i[0] = 1'b0;
        idle(4);
        rd(0, d);
        chk("R7 falling captured", d, 32'h0100_0000);
        rd(5, d);
        chk("R6 R7 overwrite lo", d, 32'hCCCC_DDDD);
    endtask

    task automatic test_status();
        logic [31:0] d;
        stat_vec_i = 6'h2D;
        rd(2, d);
        chk("R9 status", d, 32'h2D);
        stat_vec_i = 6'h3F;
        rd(2, d);
        chk("R9 status all", d, 32'h3F);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_sources();
        test_clear();
        test_collide();
        test_mask();
        wr(1, 32'h0);
        test_capture();
        test_polarity();
        test_status();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule